// File: doc/BRIEF.md
# Hub Port Change Interrupt Aggregator

This block gathers the event pulses that a downstream-port repeater reports for each hub port and turns them into one hub interrupt request. Three kinds of event are tracked for every port: a change of attachment (device connected or removed), babble, and resume signalling. Each qualifying event sets its own sticky status bit. The interrupt request is high whenever any status bit is set.

Babble and resume events count only when that port's enable bit is high. An attachment change counts only while the port is driven by the interface engine. While firmware forces the port, attachment changes are dropped. Firmware reads the status vector to find the cause. It then clears individual bits by pulsing a clear strobe with a write-one-to-clear mask. If an event arrives in the same cycle as the clear of its bit, the event wins.

Top module: `hub_irq_top`

## Requirements
- R1: While reset (rstN low) is applied and in the first cycle after it, every bit of eventStatus is 0 and hubIrq is 0.
- R2: A connChgEvt pulse on port p while portForced[p] is 0 sets eventStatus[3*p+0] at the next rising clock edge.
- R3: A connChgEvt pulse on port p while portForced[p] is 1 leaves eventStatus[3*p+0] unchanged.
- R4: A babbleEvt pulse on port p sets eventStatus[3*p+1] at the next edge only when irqEnable[p] is 1; with irqEnable[p] at 0 the bit is left unchanged.
- R5: A resumeEvt pulse on port p sets eventStatus[3*p+2] at the next edge only when irqEnable[p] is 1; with irqEnable[p] at 0 the bit is left unchanged.
- R6: hubIrq is 1 exactly when at least one bit of eventStatus is 1, in the same cycle.
- R7: A set status bit stays set until it is cleared. Removing the event, dropping irqEnable or raising portForced does not clear it.
- R8: When clrStrobe is 1, every status bit whose clrMask bit is 1 (same layout as eventStatus) is 0 after the next edge. Bits whose mask bit is 0 are unchanged. While clrStrobe is 0, clrMask has no effect.
- R9: If a qualifying event for a bit arrives in the same cycle as a clear of that bit, the bit is 1 after the edge.
- R10: An event on port p affects only the three status bits of port p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| connChgEvt | input | NUM_PORTS | Attachment change pulse, one bit per port |
| babbleEvt | input | NUM_PORTS | Babble detection pulse, one bit per port |
| resumeEvt | input | NUM_PORTS | Resume detection pulse, one bit per port |
| irqEnable | input | NUM_PORTS | Per-port enable for babble and resume events |
| portForced | input | NUM_PORTS | Port is forced by firmware; attachment changes are ignored |
| clrStrobe | input | 1 | Applies clrMask this cycle |
| clrMask | input | 3*NUM_PORTS | Write-one-to-clear mask, same layout as eventStatus |
| eventStatus | output | 3*NUM_PORTS | Sticky bits; bit 3*p+0 attachment change, 3*p+1 babble, 3*p+2 resume |
| hubIrq | output | 1 | Hub interrupt request, OR of all status bits |

## Verification
The bench builds the block with the default of four ports. With four ports, events can reach the lowest and highest port in the same cycle, and forcing and enables can differ from one neighbouring port to the next. That setting exposes index slips between ports and between event kinds. It also lets a clear and a new event meet on one bit while other bits stay untouched.

// File: rtl/hub_irq_pkg.sv
package hub_irq_pkg;
  localparam int KINDS = 3;

  typedef enum int {
    KIND_CONN   = 0,
    KIND_BABBLE = 1,
    KIND_RESUME = 2
  } evt_kind_e;
endpackage

// File: rtl/hub_irq_ctrl.sv
module hub_irq_ctrl
  import hub_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int BITS = KINDS * NUM_PORTS
) (
  input  logic [NUM_PORTS-1:0] connChgEvt,
  input  logic [NUM_PORTS-1:0] babbleEvt,
  input  logic [NUM_PORTS-1:0] resumeEvt,
  input  logic [NUM_PORTS-1:0] irqEnable,
  input  logic [NUM_PORTS-1:0] portForced,
  input  logic                 clrStrobe,
  input  logic [BITS-1:0]      clrMask,
  output logic [BITS-1:0]      setStb,
  output logic [BITS-1:0]      clrStb
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign setStb[KINDS*p + KIND_CONN]   = connChgEvt[p] & ~portForced[p];
    assign setStb[KINDS*p + KIND_BABBLE] = babbleEvt[p] & irqEnable[p];
    assign setStb[KINDS*p + KIND_RESUME] = resumeEvt[p] & irqEnable[p];
  end

  assign clrStb = clrStrobe ? clrMask : '0;
endmodule

// File: rtl/hub_irq_datapath.sv
module hub_irq_datapath
  import hub_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int BITS = KINDS * NUM_PORTS
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [BITS-1:0] setStb,
  input  logic [BITS-1:0] clrStb,
  output logic [BITS-1:0] stickyQ,
  output logic            anySet
);
  for (genvar b = 0; b < BITS; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN) stickyQ[b] <= 1'b0;
      else       stickyQ[b] <= (stickyQ[b] & ~clrStb[b]) | setStb[b];
    end
  end

  assign anySet = |stickyQ;
endmodule

// File: rtl/hub_irq_top.sv
module hub_irq_top
  import hub_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int BITS = KINDS * NUM_PORTS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] connChgEvt,
  input  logic [NUM_PORTS-1:0] babbleEvt,
  input  logic [NUM_PORTS-1:0] resumeEvt,
  input  logic [NUM_PORTS-1:0] irqEnable,
  input  logic [NUM_PORTS-1:0] portForced,
  input  logic                 clrStrobe,
  input  logic [BITS-1:0]      clrMask,
  output logic [BITS-1:0]      eventStatus,
  output logic                 hubIrq
);
  typedef struct packed {
    logic [BITS-1:0] setMask;
    logic [BITS-1:0] clrMask;
  } strobe_t;

  strobe_t stb;

  hub_irq_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .connChgEvt (connChgEvt),
    .babbleEvt  (babbleEvt),
    .resumeEvt  (resumeEvt),
    .irqEnable  (irqEnable),
    .portForced (portForced),
    .clrStrobe  (clrStrobe),
    .clrMask    (clrMask),
    .setStb     (stb.setMask),
    .clrStb     (stb.clrMask)
  );

  hub_irq_datapath #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .setStb  (stb.setMask),
    .clrStb  (stb.clrMask),
    .stickyQ (eventStatus),
    .anySet  (hubIrq)
  );
endmodule

// File: rtl/hub_irq_checker.sv
module hub_irq_checker
  import hub_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int BITS = KINDS * NUM_PORTS
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] connChgEvt,
  input logic [NUM_PORTS-1:0] babbleEvt,
  input logic [NUM_PORTS-1:0] resumeEvt,
  input logic [NUM_PORTS-1:0] irqEnable,
  input logic [NUM_PORTS-1:0] portForced,
  input logic                 clrStrobe,
  input logic [BITS-1:0]      clrMask,
  input logic [BITS-1:0]      eventStatus,
  input logic                 hubIrq
);
  // R6: request follows the status vector
  a_r6_irq_matches_status: assert property (@(posedge clk) disable iff (!rstN)
    hubIrq == (eventStatus != '0));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    localparam int C = KINDS*p + KIND_CONN;
    localparam int B = KINDS*p + KIND_BABBLE;
    localparam int S = KINDS*p + KIND_RESUME;

    // R2 / R9: unforced attachment change always lands, even against a clear
    a_r2_conn_sets: assert property (@(posedge clk) disable iff (!rstN)
      (connChgEvt[p] && !portForced[p]) |=> eventStatus[C]);

    // R3: forced port drops attachment changes
    a_r3_forced_drops: assert property (@(posedge clk) disable iff (!rstN)
      (connChgEvt[p] && portForced[p] && !eventStatus[C]) |=> !eventStatus[C]);

    // R4: babble gated by enable
    a_r4_babble_gated: assert property (@(posedge clk) disable iff (!rstN)
      (babbleEvt[p] && !irqEnable[p] && !eventStatus[B]) |=> !eventStatus[B]);

    // R5 / R9: enabled resume always lands
    a_r5_resume_sets: assert property (@(posedge clk) disable iff (!rstN)
      (resumeEvt[p] && irqEnable[p]) |=> eventStatus[S]);

    // R7: no clear, bit holds
    a_r7_sticky_conn: assert property (@(posedge clk) disable iff (!rstN)
      (eventStatus[C] && !(clrStrobe && clrMask[C])) |=> eventStatus[C]);

    // R8: clear without competing event empties the bit
    a_r8_clear_babble: assert property (@(posedge clk) disable iff (!rstN)
      (clrStrobe && clrMask[B] && !(babbleEvt[p] && irqEnable[p])) |=> !eventStatus[B]);
  end
endmodule

bind hub_irq_top hub_irq_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (.*);

// File: tb/hub_irq_top_test.sv
module hub_irq_top_test;
  localparam int N = 4;
  localparam int W = 3 * N;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] connChgEvt = '0, babbleEvt = '0, resumeEvt = '0;
  logic [N-1:0] irqEnable = '0, portForced = '0;
  logic clrStrobe = 1'b0;
  logic [W-1:0] clrMask = '0;
  logic [W-1:0] eventStatus;
  logic hubIrq;

  always #10 clk = ~clk;

  hub_irq_top #(.NUM_PORTS(N)) uut (
    .clk(clk), .rstN(rstN), .connChgEvt(connChgEvt), .babbleEvt(babbleEvt),
    .resumeEvt(resumeEvt), .irqEnable(irqEnable), .portForced(portForced),
    .clrStrobe(clrStrobe), .clrMask(clrMask), .eventStatus(eventStatus),
    .hubIrq(hubIrq)
  );

  typedef struct {
    string        tag;
    logic [W-1:0] st;
  } exp_t;

  exp_t expQ[$];
  logic [W-1:0] model = '0;
  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  task automatic check(string tag, logic [W-1:0] expSt);
    vectors++;
    if (eventStatus !== expSt || hubIrq !== (expSt != '0)) begin
      miscompares++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               tag, eventStatus, hubIrq, expSt, (expSt != '0));
    end
  endtask

  // monitor: one result per driven cycle, just after the capturing edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(e.tag, e.st);
    end
  end

  task automatic step(string tag, logic [N-1:0] c, logic [N-1:0] b, logic [N-1:0] r,
                      logic [N-1:0] en, logic [N-1:0] f, logic cs, logic [W-1:0] cm);
    logic [W-1:0] setV;
    exp_t e;
    @(negedge clk);
    connChgEvt = c; babbleEvt = b; resumeEvt = r;
    irqEnable = en; portForced = f; clrStrobe = cs; clrMask = cm;
    setV = '0;
    for (int p = 0; p < N; p++) begin
      setV[3*p+0] = c[p] & ~f[p];
      setV[3*p+1] = b[p] & en[p];
      setV[3*p+2] = r[p] & en[p];
    end
    model = (model & ~(cs ? cm : '0)) | setV;
    e.tag = tag;
    e.st  = model;
    expQ.push_back(e);
  endtask

  function automatic logic [W-1:0] bitAt(int p, int k);
    logic [W-1:0] v = '0;
    v[3*p+k] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 during reset", '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", '0);

    step("R2 conn p0 unforced", 4'b0001, '0, '0, '0, '0, 0, '0);
    step("R3 conn p1 forced", 4'b0010, '0, '0, '0, 4'b0010, 0, '0);
    step("R4 babble p2 disabled", '0, 4'b0100, '0, 4'b1011, '0, 0, '0);
    step("R4 babble p2 enabled", '0, 4'b0100, '0, 4'b0100, '0, 0, '0);
    step("R5 resume p3 disabled", '0, '0, 4'b1000, 4'b0111, '0, 0, '0);
    step("R5 resume p3 enabled", '0, '0, 4'b1000, 4'b1000, '0, 0, '0);
    step("R7 hold, enable dropped, forced", '0, '0, '0, '0, 4'b1111, 0, '0);
    step("R8 mask ignored without strobe", '0, '0, '0, '0, '0, 0, {W{1'b1}});
    step("R8 clear conn p0 only", '0, '0, '0, '0, '0, 1, bitAt(0, 0));
    step("R9 clear p3 resume with new resume", '0, '0, 4'b1000, 4'b1000, '0, 1, bitAt(3, 2));
    step("R8 clear p2 babble", '0, '0, '0, '0, '0, 1, bitAt(2, 1));
    step("R6 clear all drops irq", '0, '0, '0, '0, '0, 1, {W{1'b1}});
    step("R10 conn p3 alone", 4'b1000, '0, '0, '0, '0, 0, '0);
    step("R10 babble p0 alone", '0, 4'b0001, '0, 4'b0001, '0, 0, '0);
    step("R6 clear all", '0, '0, '0, '0, '0, 1, {W{1'b1}});
    step("R10 mixed all ports", 4'b1111, 4'b1111, 4'b1111, 4'b0101, 4'b0110, 0, '0);
    step("R9 clear all with events", 4'b0001, '0, 4'b0100, 4'b0100, '0, 1, {W{1'b1}});
    step("R7 idle hold", '0, '0, '0, '0, '0, 0, '0);
    step("R6 final clear", '0, '0, '0, '0, '0, 1, {W{1'b1}});
    step("R6 idle after clear", '0, '0, '0, '0, '0, 0, '0);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule